// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Pair

This block performs 32-bit integer multiplication and division, signed or unsigned, and holds the results in a pair of result registers called HI and LO. A multiply places the upper half of its double-width product in HI and the lower half in LO. A divide places the quotient in LO and the remainder in HI.

Division by zero never traps. It produces fixed values instead. The single signed overflow case, the most negative value divided by minus one, also produces a fixed result. Both engines work one bit per clock. While an operation is running, the `busy` output is high, new operations are refused, and any read of HI or LO waits until the new result is in place.

A host issues work through a one-cycle `op_valid` strobe carrying an operation code and two operands. It reads the registers back through a request/valid pair. Two further operation codes load HI or LO directly from an operand.

Top module: `muldiv_hilo`

## Requirements
- R1: Operation code 0 (signed multiply) forms the full 64-bit two's-complement product of `op_a` and `op_b`. HI receives bits 63:32 and LO receives bits 31:0.
- R2: Operation code 1 (unsigned multiply) forms the 64-bit unsigned product, split between HI and LO in the same way as R1.
- R3: Operation code 2 (signed divide) with a nonzero divisor truncates toward zero. LO receives the quotient. HI receives the remainder, which carries the sign of the dividend.
- R4: Operation code 3 (unsigned divide) with a nonzero divisor places the quotient in LO and the remainder in HI.
- R5: A signed divide by zero sets HI to the dividend. It sets LO to 1 when the dividend is negative and to 0xFFFFFFFF otherwise.
- R6: An unsigned divide by zero sets LO to 0xFFFFFFFF and HI to the dividend.
- R7: A signed divide of 0x80000000 by 0xFFFFFFFF yields LO = 0x80000000 and HI = 0.
- R8: Operation code 4 loads HI from `op_a` and operation code 5 loads LO from `op_a`. The load takes effect at the accepting edge and never raises `busy`.
- R9: A read request taken while idle returns the register selected by `rd_sel` (1 = HI, 0 = LO) on `rd_data`. `rd_valid` is high for exactly one cycle, starting in the cycle after the request.
- R10: After a multiply or divide is accepted, `busy` is high for exactly 33 cycles (WIDTH+1). HI and LO hold the new result in the cycle in which `busy` is first low again.
- R11: An `op_valid` presented while `busy` is high has no effect on HI, LO or timing. Operation codes 6 and 7 are also ignored.
- R12: A read requested while `busy` is high is held until the running operation finishes. It then returns the new result, and `rd_valid` never rises while `busy` is high.
- R13: After reset, HI and LO are zero and `busy` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One-cycle strobe that presents an operation |
| op_code | input | 3 | Operation selector (0..5 used) |
| op_a | input | 32 | First operand: multiplicand, dividend, or HI/LO load value |
| op_b | input | 32 | Second operand: multiplier or divisor |
| busy | output | 1 | High while a multiply or divide is running |
| rd_req | input | 1 | One-cycle read request |
| rd_sel | input | 1 | Read select: 1 = HI, 0 = LO |
| rd_valid | output | 1 | One-cycle marker for valid read data |
| rd_data | output | 32 | Read data |

## Verification
The bench drives inputs and samples outputs at falling edges. Counted from the edge that accepts a multiply or divide, `busy` reads high at exactly 33 consecutive falling edges, and the bench checks that count before it reads HI and LO. A direct HI/LO load is due after a single edge with `busy` staying low. An idle read shows `rd_valid` at the first falling edge after the request. A read made during a busy period is expected at the falling edge after the edge at which `busy` drops, and the bench flags any `rd_valid` that appears while `busy` is still high.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [2:0] {
    MD_MUL_S = 3'd0,
    MD_MUL_U = 3'd1,
    MD_DIV_S = 3'd2,
    MD_DIV_U = 3'd3,
    MD_SET_HI = 3'd4,
    MD_SET_LO = 3'd5
  } md_op_e;

  // Magnitude of a value, taken only when the operation is signed.
  function automatic logic [31:0] md_mag32(input logic [31:0] v, input logic sgn);
    return (sgn && v[31]) ? (~v + 32'd1) : v;
  endfunction
endpackage

// File: rtl/muldiv_mul.sv
module muldiv_mul #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               is_signed,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic               done,
  output logic [2*WIDTH-1:0] prod
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [2*WIDTH-1:0] acc_q;
  logic [WIDTH-1:0]   mcand_q;
  logic               neg_q;
  logic [CW-1:0]      cnt_q;
  logic               run_q;
  logic               done_q;

  logic [WIDTH:0]     part_sum;
  logic [2*WIDTH-1:0] acc_next;

  function automatic logic [WIDTH-1:0] mag(input logic [WIDTH-1:0] v, input logic sgn);
    return (sgn && v[WIDTH-1]) ? (~v + WIDTH'(1)) : v;
  endfunction

  // One shift-add step: add multiplicand when the low multiplier bit is set.
  always_comb begin
    part_sum = {1'b0, acc_q[2*WIDTH-1:WIDTH]} + (acc_q[0] ? {1'b0, mcand_q} : '0);
    acc_next = {part_sum, acc_q[WIDTH-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      mcand_q <= '0;
      neg_q   <= 1'b0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        acc_q   <= {{WIDTH{1'b0}}, mag(a, is_signed)};
        mcand_q <= mag(b, is_signed);
        neg_q   <= is_signed & (a[WIDTH-1] ^ b[WIDTH-1]);
        cnt_q   <= '0;
        run_q   <= 1'b1;
      end else if (run_q) begin
        acc_q <= acc_next;
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == LAST) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign prod = neg_q ? (~acc_q + (2*WIDTH)'(1)) : acc_q;

  // R11
  mul_start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> (!run_q && !done_q));
  // R10
  mul_done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             is_signed,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic             done,
  output logic [WIDTH-1:0] quo,
  output logic [WIDTH-1:0] rem
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [WIDTH-1:0] quo_q;
  logic [WIDTH-1:0] rem_q;
  logic [WIDTH-1:0] dsr_q;
  logic [WIDTH-1:0] dvd_q;
  logic             qneg_q;
  logic             rneg_q;
  logic             zero_q;
  logic             sgn_q;
  logic [CW-1:0]    cnt_q;
  logic             run_q;
  logic             done_q;

  logic [WIDTH:0]   shifted;
  logic [WIDTH:0]   trial;
  logic             fits;

  function automatic logic [WIDTH-1:0] mag(input logic [WIDTH-1:0] v, input logic sgn);
    return (sgn && v[WIDTH-1]) ? (~v + WIDTH'(1)) : v;
  endfunction

  // Restoring step: bring in the next dividend bit and try a subtraction.
  always_comb begin
    shifted = {rem_q, quo_q[WIDTH-1]};
    trial   = shifted - {1'b0, dsr_q};
    fits    = (shifted >= {1'b0, dsr_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quo_q  <= '0;
      rem_q  <= '0;
      dsr_q  <= '0;
      dvd_q  <= '0;
      qneg_q <= 1'b0;
      rneg_q <= 1'b0;
      zero_q <= 1'b0;
      sgn_q  <= 1'b0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        quo_q  <= mag(a, is_signed);
        rem_q  <= '0;
        dsr_q  <= mag(b, is_signed);
        dvd_q  <= a;
        qneg_q <= is_signed & (a[WIDTH-1] ^ b[WIDTH-1]);
        rneg_q <= is_signed & a[WIDTH-1];
        zero_q <= (b == '0);
        sgn_q  <= is_signed;
        cnt_q  <= '0;
        run_q  <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? trial[WIDTH-1:0] : shifted[WIDTH-1:0];
        quo_q <= {quo_q[WIDTH-2:0], fits};
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == LAST) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // Result selection. The most-negative / minus-one case falls out of the
  // magnitude path: 2^(W-1) / 1 with both signs negative keeps the bit pattern.
  always_comb begin
    if (zero_q) begin
      quo = (sgn_q && dvd_q[WIDTH-1]) ? WIDTH'(1) : '1;
      rem = dvd_q;
    end else begin
      quo = qneg_q ? (~quo_q + WIDTH'(1)) : quo_q;
      rem = rneg_q ? (~rem_q + WIDTH'(1)) : rem_q;
    end
  end

  assign done = done_q;

  // R11
  div_start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> (!run_q && !done_q));
  // R10
  div_done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R3
  div_rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && !zero_q) |-> (rem_q < dsr_q));
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             busy,
  input  logic             rd_req,
  input  logic             rd_sel,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data
);
  import muldiv_pkg::*;

  logic [WIDTH-1:0]   hi_q, lo_q;
  logic               busy_q;
  logic               rd_valid_q;
  logic [WIDTH-1:0]   rd_data_q;
  logic               rd_pend_q;
  logic               rd_sel_q;

  logic               accept;
  logic               mul_start, div_start;
  logic               op_signed;
  logic               mul_done, div_done;
  logic [2*WIDTH-1:0] mul_prod;
  logic [WIDTH-1:0]   div_quo, div_rem;
  logic               rd_want;
  logic               rd_which;

  always_comb begin
    accept    = op_valid && !busy_q;
    mul_start = accept && ((op_code == MD_MUL_S) || (op_code == MD_MUL_U));
    div_start = accept && ((op_code == MD_DIV_S) || (op_code == MD_DIV_U));
    op_signed = (op_code == MD_MUL_S) || (op_code == MD_DIV_S);
    rd_want   = rd_req || rd_pend_q;
    rd_which  = rd_pend_q ? rd_sel_q : rd_sel;
  end

  muldiv_mul #(.WIDTH(WIDTH)) mul_i (
    .clk(clk), .rst(rst), .start(mul_start), .is_signed(op_signed),
    .a(op_a), .b(op_b), .done(mul_done), .prod(mul_prod)
  );

  muldiv_div #(.WIDTH(WIDTH)) div_i (
    .clk(clk), .rst(rst), .start(div_start), .is_signed(op_signed),
    .a(op_a), .b(op_b), .done(div_done), .quo(div_quo), .rem(div_rem)
  );

  // Result registers and the busy flag.
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      lo_q   <= '0;
      busy_q <= 1'b0;
    end else begin
      if (mul_start || div_start) busy_q <= 1'b1;
      else if (mul_done || div_done) busy_q <= 1'b0;

      if (mul_done) begin
        hi_q <= mul_prod[2*WIDTH-1:WIDTH];
        lo_q <= mul_prod[WIDTH-1:0];
      end else if (div_done) begin
        hi_q <= div_rem;
        lo_q <= div_quo;
      end else if (accept && op_code == MD_SET_HI) begin
        hi_q <= op_a;
      end else if (accept && op_code == MD_SET_LO) begin
        lo_q <= op_a;
      end
    end
  end

  // Read port: served when idle, otherwise parked until busy clears.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      rd_pend_q  <= 1'b0;
      rd_sel_q   <= 1'b0;
    end else begin
      rd_valid_q <= 1'b0;
      if (rd_want && !busy_q) begin
        rd_valid_q <= 1'b1;
        rd_data_q  <= rd_which ? hi_q : lo_q;
        rd_pend_q  <= 1'b0;
      end else if (rd_req && !rd_pend_q) begin
        rd_pend_q <= 1'b1;
        rd_sel_q  <= rd_sel;
      end
    end
  end

  assign busy     = busy_q;
  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  // R8
  set_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !busy_q && op_code == MD_SET_HI) |=> (hi_q == $past(op_a) && !busy_q));
  // R12
  rd_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid_q |-> !$past(busy_q));
  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> $past(mul_done || div_done));
  // R1
  mul_write_chk: assert property (@(posedge clk) disable iff (rst)
    mul_done |=> ({hi_q, lo_q} == $past(mul_prod)));
  // R11
  single_engine_chk: assert property (@(posedge clk) disable iff (rst)
    !(mul_done && div_done));
endmodule

// File: tb/muldiv_hilo_tb_top.sv
module muldiv_hilo_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic         op_valid;
  logic [2:0]   op_code;
  logic [W-1:0] op_a, op_b;
  logic         busy;
  logic         rd_req, rd_sel;
  logic         rd_valid;
  logic [W-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  muldiv_hilo #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_a(op_a), .op_b(op_b), .busy(busy), .rd_req(rd_req),
    .rd_sel(rd_sel), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [63:0] ref_mul(input bit sgn, input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] sa, sb;
    if (sgn) begin
      sa = {{32{a[31]}}, a};
      sb = {{32{b[31]}}, b};
      return sa * sb;
    end
    return {32'd0, a} * {32'd0, b};
  endfunction

  // Returns {HI, LO}
  function automatic logic [63:0] ref_div(input bit sgn, input logic [31:0] a, input logic [31:0] b);
    logic signed [31:0] sa, sb, q, r;
    if (b == 0) return {a, (sgn && a[31]) ? 32'd1 : 32'hFFFF_FFFF};
    if (sgn && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return {32'd0, 32'h8000_0000};
    if (sgn) begin
      sa = a; sb = b;
      q = sa / sb;
      r = sa % sb;
      return {r, q};
    end
    return {a % b, a / b};
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [2:0] code, input logic [31:0] a, input logic [31:0] b, output int cyc);
    @(negedge clk);
    op_valid = 1'b1; op_code = code; op_a = a; op_b = b;
    @(negedge clk);
    op_valid = 1'b0;
    cyc = 0;
    while (busy && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic read_reg(input logic sel, output logic [31:0] d);
    int t;
    @(negedge clk);
    rd_req = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_req = 1'b0;
    t = 0;
    while (!rd_valid && t < 200) begin
      @(negedge clk);
      t++;
    end
    d = rd_data;
  endtask

  task automatic run_op(input string req, input logic [2:0] code, input logic [31:0] a, input logic [31:0] b);
    int cyc;
    logic [31:0] h, l;
    logic [63:0] exp;
    bit sgn;
    sgn = (code == 3'd0) || (code == 3'd2);
    exp = (code <= 3'd1) ? ref_mul(sgn, a, b) : ref_div(sgn, a, b);
    issue(code, a, b, cyc);
    check({req, " R10 busy cycles"}, 64'(cyc), 64'(W + 1));
    read_reg(1'b1, h);
    read_reg(1'b0, l);
    check(req, {h, l}, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, h, l;
    int cyc;
    bit bad;
    void'($urandom(32'd20240611));
    rst = 1'b1; op_valid = 1'b0; op_code = '0; op_a = '0; op_b = '0;
    rd_req = 1'b0; rd_sel = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R13 reset state
    check("R13 busy", 64'(busy), 64'd0);
    check("R13 rd_valid", 64'(rd_valid), 64'd0);
    read_reg(1'b1, d); check("R13 HI", 64'(d), 64'd0);
    read_reg(1'b0, d); check("R13 LO", 64'(d), 64'd0);

    // R9 read timing: rd_valid one cycle, next cycle after request
    @(negedge clk); rd_req = 1'b1; rd_sel = 1'b0;
    @(negedge clk); rd_req = 1'b0;
    check("R9 rd_valid next cycle", 64'(rd_valid), 64'd1);
    @(negedge clk);
    check("R9 rd_valid one cycle", 64'(rd_valid), 64'd0);

    // R8 direct loads
    issue(3'd4, 32'hCAFE_0001, 32'h0, cyc);
    check("R8 no busy", 64'(cyc), 64'd0);
    issue(3'd5, 32'h1234_5678, 32'h0, cyc);
    read_reg(1'b1, d); check("R8 HI load", 64'(d), 64'hCAFE_0001);
    read_reg(1'b0, d); check("R8 LO load", 64'(d), 64'h1234_5678);

    // R11 unused codes ignored
    issue(3'd6, 32'hAAAA_AAAA, 32'h5, cyc);
    issue(3'd7, 32'hBBBB_BBBB, 32'h5, cyc);
    check("R11 unused code busy", 64'(cyc), 64'd0);
    read_reg(1'b1, h); read_reg(1'b0, l);
    check("R11 unused code", {h, l}, {32'hCAFE_0001, 32'h1234_5678});

    // Directed multiply and divide corners
    run_op("R1 neg*pos", 3'd0, 32'hFFFF_FFFE, 32'd7);
    run_op("R1 min*min", 3'd0, 32'h8000_0000, 32'h8000_0000);
    run_op("R2 max*max", 3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op("R3 neg/pos", 3'd2, 32'hFFFF_FFF9, 32'd2);
    run_op("R3 pos/neg", 3'd2, 32'd7, 32'hFFFF_FFFE);
    run_op("R4 big/small", 3'd3, 32'hFFFF_FFFF, 32'd10);
    run_op("R5 neg/0", 3'd2, 32'hFFFF_FF00, 32'd0);
    run_op("R5 pos/0", 3'd2, 32'h0000_1234, 32'd0);
    run_op("R6 udiv/0", 3'd3, 32'h8765_4321, 32'd0);
    run_op("R7 min/-1", 3'd2, 32'h8000_0000, 32'hFFFF_FFFF);

    // Random mix
    for (int i = 0; i < 30; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = ($urandom % 4 == 0) ? ($urandom % 4) : $urandom;
      run_op("R1 rand", 3'd0, ra, rb);
      run_op("R2 rand", 3'd1, ra, rb);
      run_op("R3 rand", 3'd2, ra, rb);
      run_op("R4 rand", 3'd3, ra, rb);
    end

    // R11 op while busy ignored
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'd1; op_a = 32'h0001_0000; op_b = 32'h0003_0000;
    @(negedge clk);
    op_code = 3'd4; op_a = 32'hDEAD_BEEF; op_b = 32'h0;
    @(negedge clk);
    op_code = 3'd2; op_a = 32'd100; op_b = 32'd3;
    @(negedge clk);
    op_valid = 1'b0;
    cyc = 2;
    while (busy && cyc < 200) begin @(negedge clk); cyc++; end
    check("R11 timing kept", 64'(cyc), 64'(W + 1));
    read_reg(1'b1, h); read_reg(1'b0, l);
    check("R11 busy op ignored", {h, l}, ref_mul(1'b0, 32'h0001_0000, 32'h0003_0000));

    // R12 read during busy stalls and returns the new result
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'd3; op_a = 32'd1000; op_b = 32'd7;
    @(negedge clk);
    op_valid = 1'b0;
    rd_req = 1'b1; rd_sel = 1'b0;
    @(negedge clk);
    rd_req = 1'b0;
    bad = 0; cyc = 0;
    while (!rd_valid && cyc < 200) begin
      if (busy && rd_valid) bad = 1;
      @(negedge clk);
      cyc++;
    end
    check("R12 no early valid", 64'(bad), 64'd0);
    check("R12 busy low at valid", 64'(busy), 64'd0);
    check("R12 stalled read data", 64'(rd_data), 64'd142);
    read_reg(1'b1, d); check("R4 stalled div rem", 64'(d), 64'd6);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule